// File: doc/BRIEF.md
# DMA Transfer Bus-Cycle Sequencer

This block carries out a single DMA transfer unit on a shared external bus. After a start pulse it reads one operand from a source address and then writes it to a destination address. The operand is 8 or 16 bits wide. The data bus it drives is 16 bits wide, but the bus-width select can restrict it to its low 8-bit lane. Each phase is broken into as many bus cycles as its own address and the bus width require. A phase flagged as needing a software wait has every one of its bus cycles stretched.

Read bytes are gathered into a holding register before the write phase begins. The sequencer raises a one-clock done pulse once the final write cycle has ended. Address stepping across a block, channel arbitration, request triggering and terminal counting belong to the surrounding controller.

Top module: `dma_xfer_seq`

## Requirements
- R1: A transfer always finishes every read bus cycle before its first write bus cycle. The write phase starts in the clock right after the last read cycle, and the read and write strobes are never high at the same time.
- R2: On the 16-bit bus, a 16-bit operand at an even address takes one bus cycle in that phase. That cycle has byte enables 2'b11, and read data is taken from the whole bus.
- R3: On the 16-bit bus, a 16-bit operand at an odd address takes two byte cycles in that phase. The first cycle is at the base address and the second at base+1, which wraps within the address width. A byte cycle at an odd address uses byte enable 2'b10 and the upper lane. A byte cycle at an even address uses 2'b01 and the lower lane.
- R4: With the 8-bit bus selected, a 16-bit operand takes two byte cycles in each phase, at base and then base+1. Both cycles use byte enable 2'b01 and the lower lane.
- R5: Each phase is split according to its own address. An odd source with an even destination on the 16-bit bus therefore gives two read cycles and one write cycle, and the reverse case gives one read cycle and two write cycles.
- R6: An 8-bit operand always takes exactly one read cycle and one write cycle. On the 16-bit bus the lane follows address bit 0, as in R3. On the 8-bit bus it uses the lower lane.
- R7: Every bus cycle of a phase whose wait flag was set at start lasts 1+WAIT_CYCLES clocks, and a bus cycle of a phase without the flag lasts one clock. Strobe, address, byte enable and write data stay unchanged for the whole bus cycle.
- R8: A full-width write drives the assembled 16-bit value, with the byte read first in bits 7:0. A byte write drives its byte on both lanes, and the byte written first is the one that was read first.
- R9: Done is high for exactly one clock, in the clock right after the last write cycle ends.
- R10: While a transfer is running, start and all transfer inputs are ignored. Operand size, bus width, addresses and wait flags are sampled only when start is accepted in idle.
- R11: Reset, asserted at any time, returns the block to idle with both strobes, busy, done, byte enables, address and write data all at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Begin one transfer unit (taken only when idle) |
| size16_i | input | 1 | 1: 16-bit operand, 0: 8-bit operand |
| bus8_i | input | 1 | 1: 8-bit data bus (lower lane only), 0: 16-bit bus |
| src_addr_i | input | AW | Source byte address |
| dst_addr_i | input | AW | Destination byte address |
| src_wait_i | input | 1 | Stretch every read bus cycle |
| dst_wait_i | input | 1 | Stretch every write bus cycle |
| rdata_i | input | 16 | Read data from the bus |
| busy_o | output | 1 | A transfer is in progress |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| addr_o | output | AW | Bus address |
| be_o | output | 2 | Byte enables, bit 0 for the lower lane |
| wdata_o | output | 16 | Write data |
| done_o | output | 1 | One-clock completion pulse |

## Verification
The bench builds the block with AW=12 and WAIT_CYCLES=2. The narrow address width lets a split operand at the top address wrap its second byte to address zero. Two wait clocks make each stretched cycle three clocks long, so a stretch that holds its outputs for only part of the cycle, or is one clock short, is caught. The bench also varies the transfer inputs right after start, which shows whether they are sampled only when start is accepted.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int DW = 16;
  localparam int NB = DW / 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic size16;
    logic bus8;
    logic src_wait;
    logic dst_wait;
  } xfer_cfg_t;
endpackage

// File: rtl/dma_seq_plan.sv
module dma_seq_plan #(
  parameter int AW = 16
) (
  input  logic                         size16,
  input  logic                         bus8,
  input  logic [AW-1:0]                base,
  input  logic                         beat,
  output logic [AW-1:0]                addr,
  output logic [dma_seq_pkg::NB-1:0]   be,
  output logic                         word,
  output logic                         lane_hi,
  output logic                         last_beat
);
  logic split;

  always_comb begin
    split     = size16 && (bus8 || base[0]);
    addr      = base + AW'(beat);
    word      = size16 && !split;
    lane_hi   = !bus8 && addr[0];
    last_beat = split ? beat : 1'b1;
    if (word)         be = 2'b11;
    else if (lane_hi) be = 2'b10;
    else              be = 2'b01;
  end
endmodule

// File: rtl/dma_seq_timer.sv
module dma_seq_timer #(
  parameter int WAIT_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic wait_en,
  output logic cyc_end
);
  localparam int CW = (WAIT_CYCLES < 1) ? 1 : $clog2(WAIT_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    limit   = wait_en ? CW'(WAIT_CYCLES) : '0;
    cyc_end = run && (cnt_q == limit);
    if (!run || cyc_end) cnt_d = '0;
    else                 cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dma_seq_hold.sv
module dma_seq_hold (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cap_en,
  input  logic                         word,
  input  logic                         beat,
  input  logic                         lane_hi,
  input  logic [dma_seq_pkg::DW-1:0]   rdata,
  output logic [dma_seq_pkg::DW-1:0]   wdata
);
  logic [15:0] hold_q, hold_d;
  logic [7:0]  rd_byte, wr_byte;

  always_comb begin
    rd_byte = lane_hi ? rdata[15:8] : rdata[7:0];
    hold_d  = hold_q;
    if (word)      hold_d = rdata;
    else if (beat) hold_d[15:8] = rd_byte;
    else           hold_d[7:0]  = rd_byte;
    wr_byte = beat ? hold_q[15:8] : hold_q[7:0];
    wdata   = word ? hold_q : {wr_byte, wr_byte};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (cap_en) hold_q <= hold_d;
  end
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_seq_pkg::*;
#(
  parameter int AW          = 16,
  parameter int WAIT_CYCLES = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          size16_i,
  input  logic          bus8_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic          src_wait_i,
  input  logic          dst_wait_i,
  input  logic [15:0]   rdata_i,
  output logic          busy_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic [AW-1:0] addr_o,
  output logic [1:0]    be_o,
  output logic [15:0]   wdata_o,
  output logic          done_o
);
  seq_state_e    state_q, state_d;
  logic          beat_q, beat_d;
  logic          done_q, done_d;
  logic          ld_cfg;
  xfer_cfg_t     cfg_q;
  logic [AW-1:0] src_q, dst_q, cur_base, cur_addr;
  logic [NB-1:0] cur_be;
  logic [DW-1:0] hold_wdata;
  logic          run, cur_wait, cyc_end, word, lane_hi, last_beat, cap_en;

  always_comb begin
    run      = (state_q != ST_IDLE);
    cur_base = (state_q == ST_WRITE) ? dst_q : src_q;
    cur_wait = (state_q == ST_WRITE) ? cfg_q.dst_wait : cfg_q.src_wait;
    cap_en   = (state_q == ST_READ) && cyc_end;
  end

  dma_seq_plan #(.AW(AW)) u_plan (
    .size16    (cfg_q.size16),
    .bus8      (cfg_q.bus8),
    .base      (cur_base),
    .beat      (beat_q),
    .addr      (cur_addr),
    .be        (cur_be),
    .word      (word),
    .lane_hi   (lane_hi),
    .last_beat (last_beat)
  );

  dma_seq_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .wait_en (cur_wait),
    .cyc_end (cyc_end)
  );

  dma_seq_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (cap_en),
    .word    (word),
    .beat    (beat_q),
    .lane_hi (lane_hi),
    .rdata   (rdata_i),
    .wdata   (hold_wdata)
  );

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    done_d  = 1'b0;
    ld_cfg  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          ld_cfg  = 1'b1;
          state_d = ST_READ;
          beat_d  = 1'b0;
        end
      end
      ST_READ: begin
        if (cyc_end) begin
          if (last_beat) begin
            state_d = ST_WRITE;
            beat_d  = 1'b0;
          end else begin
            beat_d  = 1'b1;
          end
        end
      end
      ST_WRITE: begin
        if (cyc_end) begin
          if (last_beat) begin
            state_d = ST_IDLE;
            beat_d  = 1'b0;
            done_d  = 1'b1;
          end else begin
            beat_d  = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      src_q <= '0;
      dst_q <= '0;
    end else if (ld_cfg) begin
      cfg_q <= '{size16: size16_i, bus8: bus8_i,
                 src_wait: src_wait_i, dst_wait: dst_wait_i};
      src_q <= src_addr_i;
      dst_q <= dst_addr_i;
    end
  end

  always_comb begin
    busy_o  = run;
    rd_o    = (state_q == ST_READ);
    wr_o    = (state_q == ST_WRITE);
    addr_o  = run ? cur_addr : '0;
    be_o    = run ? cur_be : '0;
    wdata_o = wr_o ? hold_wdata : '0;
    done_o  = done_q;
  end
endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_o,
  input logic       rd_o,
  input logic       wr_o,
  input logic [1:0] be_o,
  input logic       done_o
);
  a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_o && wr_o));

  a_r1_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_o) |-> $past(rd_o));

  a_r3_be_present: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_o || wr_o) |-> (be_o != 2'b00));

  a_r9_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_o) |-> done_o);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r10_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o));
endmodule

bind dma_xfer_seq dma_xfer_seq_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy_o (busy_o),
  .rd_o   (rd_o),
  .wr_o   (wr_o),
  .be_o   (be_o),
  .done_o (done_o)
);

// File: tb/dma_xfer_seq_test.sv
module dma_xfer_seq_test;
  localparam int AW = 12;
  localparam int WC = 2;
  localparam int EW = 3 + AW + 2 + 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, size16_i = 1'b0, bus8_i = 1'b0;
  logic src_wait_i = 1'b0, dst_wait_i = 1'b0;
  logic [AW-1:0] src_addr_i = '0, dst_addr_i = '0;
  logic [15:0] rdata_i;
  logic busy_o, rd_o, wr_o, done_o;
  logic [AW-1:0] addr_o;
  logic [1:0] be_o;
  logic [15:0] wdata_o;

  int checks = 0;
  int bad = 0;
  bit finished = 0;
  logic cur_bus8 = 1'b0;
  string tag = "R11";
  logic [EW-1:0] expq[$];

  always #10 clk = ~clk;

  dma_xfer_seq #(.AW(AW), .WAIT_CYCLES(WC)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .size16_i(size16_i),
    .bus8_i(bus8_i), .src_addr_i(src_addr_i), .dst_addr_i(dst_addr_i),
    .src_wait_i(src_wait_i), .dst_wait_i(dst_wait_i), .rdata_i(rdata_i),
    .busy_o(busy_o), .rd_o(rd_o), .wr_o(wr_o), .addr_o(addr_o),
    .be_o(be_o), .wdata_o(wdata_o), .done_o(done_o));

  function automatic logic [7:0] mem(input logic [AW-1:0] a);
    logic [15:0] t;
    t = 16'(a) * 16'd7 + 16'h35;
    return t[7:0];
  endfunction

  always_comb begin
    if (cur_bus8) rdata_i = {8'hEE, mem(addr_o)};
    else          rdata_i = {mem(addr_o | AW'(1)), mem(addr_o & ~AW'(1))};
  end

  function automatic logic [EW-1:0] ent(input logic r, input logic w, input logic d,
      input logic [AW-1:0] a, input logic [1:0] b, input logic [15:0] wd);
    return {r, w, d, a, b, wd};
  endfunction

  task automatic plan(input logic s16, input logic b8, input logic [AW-1:0] sa,
      input logic [AW-1:0] da, input logic sw, input logic dw);
    logic [15:0] val;
    logic [AW-1:0] a;
    logic [1:0] b;
    logic [7:0] by;
    int nr, nw;
    bit rword, wword;
    val    = s16 ? {mem(sa + AW'(1)), mem(sa)} : {8'h00, mem(sa)};
    rword  = s16 && !b8 && !sa[0];
    wword  = s16 && !b8 && !da[0];
    nr     = (s16 && !rword) ? 2 : 1;
    nw     = (s16 && !wword) ? 2 : 1;
    for (int k = 0; k < nr; k++) begin
      a = sa + AW'(k);
      b = rword ? 2'b11 : ((!b8 && a[0]) ? 2'b10 : 2'b01);
      for (int c = 0; c < (sw ? 1 + WC : 1); c++) expq.push_back(ent(1, 0, 0, a, b, 16'h0));
    end
    for (int k = 0; k < nw; k++) begin
      a  = da + AW'(k);
      b  = wword ? 2'b11 : ((!b8 && a[0]) ? 2'b10 : 2'b01);
      by = (k == 1) ? val[15:8] : val[7:0];
      for (int c = 0; c < (dw ? 1 + WC : 1); c++)
        expq.push_back(ent(0, 1, 0, a, b, wword ? val : {by, by}));
    end
    expq.push_back(ent(0, 0, 1, '0, 2'b00, 16'h0));
  endtask

  task automatic check_now();
    logic [EW-1:0] e, act;
    e = (expq.size() > 0) ? expq.pop_front() : ent(0, 0, 0, '0, 2'b00, 16'h0);
    act = {rd_o, wr_o, done_o, addr_o, be_o, wdata_o};
    if (!e[EW-1] && !e[EW-2]) begin
      e[AW+17:0] = '0;
    end else if (!e[EW-2]) begin
      e[15:0]    = 16'h0;
    end
    checks++;
    if (act !== e || busy_o !== (e[EW-1] | e[EW-2])) begin
      bad++;
      $display("FAIL %s t=%0t actual rd=%b wr=%b done=%b busy=%b addr=%h be=%b wd=%h expected rd=%b wr=%b done=%b addr=%h be=%b wd=%h",
        tag, $time, rd_o, wr_o, done_o, busy_o, addr_o, be_o, wdata_o,
        e[EW-1], e[EW-2], e[EW-3], e[AW+17:18], e[17:16], e[15:0]);
    end
  endtask

  task automatic step(input logic st, input logic s16, input logic b8,
      input logic [AW-1:0] sa, input logic [AW-1:0] da, input logic sw, input logic dw);
    @(negedge clk);
    check_now();
    start_i = st; size16_i = s16; bus8_i = b8;
    src_addr_i = sa; dst_addr_i = da; src_wait_i = sw; dst_wait_i = dw;
    if (st && rst_n && expq.size() == 0) begin
      cur_bus8 = b8;
      plan(s16, b8, sa, da, sw, dw);
    end
  endtask

  task automatic run(input string t, input logic s16, input logic b8,
      input logic [AW-1:0] sa, input logic [AW-1:0] da, input logic sw, input logic dw);
    tag = t;
    step(1, s16, b8, sa, da, sw, dw);
    // R10: disturb every transfer input while the unit is running
    while (expq.size() > 0) step(0, !s16, !b8, ~sa, ~da, !sw, !dw);
    step(0, 0, 0, '0, '0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    tag = "R11";
    step(0, 0, 0, '0, '0, 0, 0);
    step(1, 1, 0, '0, '0, 0, 0);
    step(0, 0, 0, '0, '0, 0, 0);
    rst_n = 1'b1;
    step(0, 0, 0, '0, '0, 0, 0);

    run("R2", 1, 0, 12'h100, 12'h200, 0, 0);
    run("R3", 1, 0, 12'h101, 12'h203, 0, 0);
    run("R4", 1, 1, 12'h040, 12'h080, 0, 0);
    run("R4", 1, 1, 12'h041, 12'h083, 0, 0);
    run("R5", 1, 0, 12'h011, 12'h020, 0, 0);
    run("R5", 1, 0, 12'h010, 12'h021, 0, 0);
    run("R6", 0, 0, 12'h031, 12'h044, 0, 0);
    run("R6", 0, 0, 12'h032, 12'h045, 0, 0);
    run("R6", 0, 1, 12'h033, 12'h046, 0, 0);
    run("R7", 1, 0, 12'h051, 12'h060, 1, 0);
    run("R7", 1, 1, 12'h070, 12'h071, 0, 1);
    run("R7", 0, 0, 12'h090, 12'h093, 1, 1);
    run("R3", 1, 0, 12'hFFF, 12'h7FF, 0, 0);
    run("R8", 1, 0, 12'h0A0, 12'h0B1, 1, 0);

    // R9/R10: start held high; accepted only on idle cycles, including the done cycle
    tag = "R9";
    for (int i = 0; i < 24; i++) step(1, 1, 0, AW'(12'h300 + i), AW'(12'h401 + i), 0, 0);
    while (expq.size() > 0) step(0, 0, 0, '0, '0, 0, 0);
    step(0, 0, 0, '0, '0, 0, 0);

    // R11: reset in the middle of a transfer
    tag = "R11";
    step(1, 1, 1, 12'h123, 12'h456, 1, 1);
    step(0, 0, 0, '0, '0, 0, 0);
    step(0, 0, 0, '0, '0, 0, 0);
    @(negedge clk);
    rst_n = 1'b0;
    expq.delete();
    step(0, 0, 0, '0, '0, 0, 0);
    rst_n = 1'b1;
    step(0, 0, 0, '0, '0, 0, 0);
    run("R2", 1, 0, 12'h600, 12'h602, 1, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule